// File: doc/BRIEF.md
# Consistent 64-bit Timestamp Snapshot Reader

This block reads a free-running 64-bit timer that can only be reached as two 32-bit halves on a single-read request/acknowledge port. A carry from the low half into the high half, or an abrupt jump of the timer, can land between the two reads. The pair read back then mixes two different moments in time. On a start pulse the sequencer reads the high half and keeps it as a reference. It then loops: read the low half, read the high half again. When the fresh high reading equals the reference, the pair is consistent and the sequencer returns it.

If the two high readings differ, the fresh reading becomes the new reference and the loop runs again. The number of loops is bounded by a parameter. If the bound is used up, the sequencer still returns the latest pair, but raises an error flag with the done pulse. In the common case a snapshot costs three reads, and every retry costs two more. The number of reads used is reported alongside the result.

Top module: `wide_time_sampler`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `done`, `error` and `rdValid` are low, and `snapshot` and `readCount` are zero.
- R2: The first request after an accepted start has `rdUpper`=1, meaning the high half. `rdUpper`=0 selects the low half. After that the requests alternate: low, high, low, high and so on.
- R3: If the high reading after a low read equals the reference, the next cycle raises `done`. `snapshot` then carries the reference in bits 63:32 and that low reading in bits 31:0. With no disagreement exactly 3 reads are used.
- R4: If the high readings disagree, the fresh high reading replaces the reference and another low/high pair is requested. Each retry adds 2 reads, so a successful snapshot reports an odd `readCount` of 3 or more.
- R5: After `MAX_TRIES` (default 10) disagreeing iterations, `done` and `error` rise together. `snapshot` then holds the last reference and the last low reading, and `readCount` equals 2*MAX_TRIES+1. A later successful snapshot clears `error`.
- R6: `rdValid` stays high with a stable `rdUpper` until `rdAck` is seen. Only one read is outstanding at a time, and `rdData` is taken in the cycle where `rdValid` and `rdAck` are both high.
- R7: `busy` is high from the cycle after an accepted start through the `done` cycle. A start while busy is ignored: no extra reads are issued and no second snapshot follows.
- R8: `done` is a single-cycle pulse. `snapshot`, `error` and `readCount` keep their values after it until the next accepted start.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new snapshot (accepted when idle) |
| busy | output | 1 | Snapshot in progress |
| done | output | 1 | One-cycle pulse: result valid |
| error | output | 1 | Retry bound exhausted for the last snapshot |
| snapshot | output | 2*HALF_W | Combined high/low timer value |
| readCount | output | RC_W | Reads issued for the last snapshot |
| rdValid | output | 1 | Read request pending |
| rdUpper | output | 1 | 1 = high half, 0 = low half |
| rdAck | input | 1 | Read completed, `rdData` valid |
| rdData | input | HALF_W | Read data |

## Verification
The hardest condition to reach is exhaustion of the retry bound. A real timer carries into its high half only once every 2^32 ticks, so it almost never produces ten disagreeing high readings in a row. The bench's timer model can be told to add a jump of one high-half unit right after each of the next J high reads. Sweeping J from 0 past the bound gives every retry depth, including the error exit. A second sweep places the low half a few ticks below rollover, under several acknowledge latencies, so that ordinary carries fall between the reads at each position in the sequence.

// File: rtl/wts_pkg.sv
package wts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_LOW,
    ST_CHK,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic captureRef;
    logic captureLow;
    logic clearCount;
    logic countRead;
  } ctlStrobes_t;

endpackage

// File: rtl/wts_datapath.sv
module wts_datapath
  import wts_pkg::*;
#(
  parameter int HALF_W    = 32,
  parameter int MAX_TRIES = 10,
  localparam int RC_W     = $clog2(2 * MAX_TRIES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strb,
  input  logic [HALF_W-1:0] rdData,
  output logic [HALF_W-1:0] refUpper,
  output logic [HALF_W-1:0] lowVal,
  output logic [RC_W-1:0]   readCount,
  output logic              upperMatch
);

  // Reference high half: loaded from the first high read and from every
  // disagreeing high read after it.
  always_ff @(posedge clk) begin
    if (rst) begin
      refUpper <= '0;
    end else if (strb.captureRef) begin
      refUpper <= rdData;
    end
  end

  // Latest low half
  always_ff @(posedge clk) begin
    if (rst) begin
      lowVal <= '0;
    end else if (strb.captureLow) begin
      lowVal <= rdData;
    end
  end

  // Reads completed for the current or last snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      readCount <= '0;
    end else if (strb.clearCount) begin
      readCount <= '0;
    end else if (strb.countRead) begin
      readCount <= readCount + RC_W'(1);
    end
  end

  // Compare the returning data against the held reference
  assign upperMatch = (rdData == refUpper);

endmodule

// File: rtl/wts_control.sv
module wts_control
  import wts_pkg::*;
#(
  parameter int MAX_TRIES = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        rdAck,
  input  logic        upperMatch,
  output ctlStrobes_t strb,
  output logic        rdValid,
  output logic        rdUpper,
  output logic        busy,
  output logic        done,
  output logic        error
);

  localparam int IT_W = $clog2(MAX_TRIES + 1);

  seqState_t state;
  seqState_t nextState;
  logic [IT_W-1:0] iterCnt;
  logic errFlag;
  logic startAcc;
  logic chkAck;
  logic chkMiss;
  logic lastIter;

  assign startAcc = (state == ST_IDLE) && start;
  assign chkAck   = (state == ST_CHK) && rdAck;
  assign chkMiss  = chkAck && !upperMatch;
  assign lastIter = (iterCnt == IT_W'(MAX_TRIES - 1));

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) nextState = ST_REF;
      ST_REF:  if (rdAck) nextState = ST_LOW;
      ST_LOW:  if (rdAck) nextState = ST_CHK;
      ST_CHK: begin
        if (rdAck) begin
          if (upperMatch || lastIter) nextState = ST_FIN;
          else                        nextState = ST_LOW;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      errFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (startAcc) begin
        iterCnt <= '0;
        errFlag <= 1'b0;
      end else if (chkMiss) begin
        iterCnt <= iterCnt + IT_W'(1);
        if (lastIter) errFlag <= 1'b1;
      end
    end
  end

  assign rdValid = (state == ST_REF) || (state == ST_LOW) || (state == ST_CHK);
  assign rdUpper = (state == ST_REF) || (state == ST_CHK);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign error   = errFlag;

  always_comb begin
    strb            = '0;
    strb.clearCount = startAcc;
    strb.countRead  = rdValid && rdAck;
    strb.captureLow = (state == ST_LOW) && rdAck;
    strb.captureRef = ((state == ST_REF) && rdAck) || chkMiss;
  end

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (rdValid && !rdAck) |=> (rdValid && $stable(rdUpper)));

  // R2
  first_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (rdValid && rdUpper));

  // R2
  low_then_up_chk: assert property (@(posedge clk) disable iff (rst)
    (rdValid && rdAck && !rdUpper) |=> (rdValid && rdUpper));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && start) |=> busy);

endmodule

// File: rtl/wide_time_sampler.sv
module wide_time_sampler
  import wts_pkg::*;
#(
  parameter int HALF_W    = 32,
  parameter int MAX_TRIES = 10,
  localparam int RC_W     = $clog2(2 * MAX_TRIES + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                error,
  output logic [2*HALF_W-1:0] snapshot,
  output logic [RC_W-1:0]     readCount,
  output logic                rdValid,
  output logic                rdUpper,
  input  logic                rdAck,
  input  logic [HALF_W-1:0]   rdData
);

  ctlStrobes_t strb;
  logic upperMatch;
  logic [HALF_W-1:0] refUpper;
  logic [HALF_W-1:0] lowVal;

  wts_control #(
    .MAX_TRIES(MAX_TRIES)
  ) u_control (
    .clk(clk),
    .rst(rst),
    .start(start),
    .rdAck(rdAck),
    .upperMatch(upperMatch),
    .strb(strb),
    .rdValid(rdValid),
    .rdUpper(rdUpper),
    .busy(busy),
    .done(done),
    .error(error)
  );

  wts_datapath #(
    .HALF_W(HALF_W),
    .MAX_TRIES(MAX_TRIES)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .rdData(rdData),
    .refUpper(refUpper),
    .lowVal(lowVal),
    .readCount(readCount),
    .upperMatch(upperMatch)
  );

  assign snapshot = {refUpper, lowVal};

  // R5
  exhaust_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> (readCount == RC_W'(2 * MAX_TRIES + 1)));

  // R4
  success_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (readCount[0] && readCount >= RC_W'(3)));

endmodule

// File: tb/wide_time_sampler_bench.sv
module wide_time_sampler_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_W     = 32;
  localparam int MAX_TRIES  = 10;
  localparam int RC_W       = $clog2(2 * MAX_TRIES + 2);

  logic clk;
  logic rst;
  logic start;
  logic busy;
  logic done;
  logic error;
  logic [2*HALF_W-1:0] snapshot;
  logic [RC_W-1:0] readCount;
  logic rdValid;
  logic rdUpper;
  logic rdAck;
  logic [HALF_W-1:0] rdData;

  int checks = 0;
  int errors = 0;

  // configuration written by the main sequence
  logic [63:0] startVal = 64'h0;
  logic [63:0] stepV = 64'h1;
  int latency = 0;
  int jumpBudget = 0;
  int loadSeq = 0;

  // owned by the timer/responder model
  logic [63:0] tsf;
  int jumpLeft;
  int lastSeq;
  int waitCnt;
  logic [31:0] logData [0:63];
  bit logUp [0:63];
  int logN;

  wide_time_sampler #(
    .HALF_W(HALF_W),
    .MAX_TRIES(MAX_TRIES)
  ) u_wide_time_sampler (
    .clk(clk),
    .rst(rst),
    .start(start),
    .busy(busy),
    .done(done),
    .error(error),
    .snapshot(snapshot),
    .readCount(readCount),
    .rdValid(rdValid),
    .rdUpper(rdUpper),
    .rdAck(rdAck),
    .rdData(rdData)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  // Timer model and read responder
  initial begin
    tsf = 64'h0; jumpLeft = 0; lastSeq = 0; waitCnt = 0; logN = 0;
    rdAck = 1'b0; rdData = '0;
    forever begin
      @(negedge clk);
      tsf = tsf + stepV;
      if (loadSeq != lastSeq) begin
        lastSeq = loadSeq;
        tsf = startVal;
        jumpLeft = jumpBudget;
        logN = 0;
      end
      if (rdAck) begin
        rdAck = 1'b0;
        waitCnt = 0;
      end else if (rdValid) begin
        if (waitCnt >= latency) begin
          rdAck = 1'b1;
          rdData = rdUpper ? tsf[63:32] : tsf[31:0];
          if (logN < 64) begin
            logData[logN] = rdData;
            logUp[logN] = rdUpper;
            logN++;
          end
          if (rdUpper && jumpLeft > 0) begin
            tsf = tsf + 64'h1_0000_0000;
            jumpLeft--;
          end
        end else begin
          waitCnt++;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference algorithm replayed over the responses actually returned
  task automatic model(output logic [63:0] eSnap, output bit eErr,
                       output int eReads, output bit orderOk);
    logic [31:0] refV;
    logic [31:0] lowV;
    logic [31:0] upV;
    int idx;
    int iterc;
    bit fin;
    refV = logData[0]; lowV = 32'h0; idx = 1; iterc = 0; eErr = 1'b0; fin = 1'b0;
    for (int it = 0; it < MAX_TRIES; it++) begin
      if (!fin) begin
        if (idx + 1 >= logN) begin
          fin = 1'b1;
        end else begin
          lowV = logData[idx];
          upV = logData[idx + 1];
          idx += 2;
          if (upV == refV) begin
            fin = 1'b1;
          end else begin
            refV = upV;
            iterc++;
            if (iterc == MAX_TRIES) begin
              eErr = 1'b1;
              fin = 1'b1;
            end
          end
        end
      end
    end
    eSnap = {refV, lowV};
    eReads = idx;
    orderOk = 1'b1;
    for (int i = 0; i < logN; i++) begin
      if (logUp[i] != ((i % 2) == 0)) orderOk = 1'b0;
    end
  endtask

  task automatic runOne(input logic [63:0] sv, input logic [63:0] st, input int lat,
                        input int jumps, input bit extraStart);
    logic [63:0] eSnap;
    bit eErr;
    int eReads;
    bit orderOk;
    int t;
    logic [63:0] heldSnap;
    logic [RC_W-1:0] heldCount;
    startVal = sv; stepV = st; latency = lat; jumpBudget = jumps;
    loadSeq++;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R7: busy rises in the cycle after the accepted start
    check(busy === 1'b1, "R7 busy after start", {63'h0, busy}, 64'h1);
    t = 0;
    while (!done && t < 400) begin
      start = (extraStart && t == 1);
      @(negedge clk);
      t++;
    end
    start = 1'b0;
    check(done === 1'b1, "R3 done reached", {63'h0, done}, 64'h1);
    model(eSnap, eErr, eReads, orderOk);
    // R2 order of half selects
    check(orderOk, "R2 read order", 64'(logN), 64'(eReads));
    // R3 R4 snapshot from consistent pair
    check(snapshot === eSnap, "R3 R4 snapshot", snapshot, eSnap);
    // R5 error flag
    check(error === eErr, "R5 error flag", {63'h0, error}, {63'h0, eErr});
    // R6 one read per acknowledge, counted
    check(int'(readCount) == eReads && logN == eReads, "R6 read count",
          64'(readCount), 64'(eReads));
    heldSnap = snapshot;
    heldCount = readCount;
    @(negedge clk);
    // R8 single-cycle done and held result
    check(done === 1'b0, "R8 done pulse", {63'h0, done}, 64'h0);
    check(snapshot === heldSnap && readCount === heldCount, "R8 result held",
          snapshot, heldSnap);
    if (extraStart) begin
      repeat (4) @(negedge clk);
      // R7 start during busy ignored: no new run
      check(busy === 1'b0 && rdValid === 1'b0 && logN == eReads,
            "R7 start ignored", 64'(logN), 64'(eReads));
    end
  endtask

  initial begin
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!busy && !done && !error && !rdValid && snapshot == '0 && readCount == '0,
          "R1 reset state", snapshot, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1 after release
    check(!busy && !done && !error && !rdValid, "R1 idle after reset",
          {60'h0, busy, done, error, rdValid}, 64'h0);

    // R3 plain snapshot, three reads
    runOne(64'h0000_0005_0000_1000, 64'h1, 1, 0, 1'b0);
    check(readCount == RC_W'(3), "R3 three reads", 64'(readCount), 64'd3);

    // Low half just below rollover at several latencies
    for (int k = 0; k < 16; k++) begin
      for (int lat = 0; lat < 4; lat++) begin
        runOne({32'h3, 32'hFFFF_FFFF - 32'(k)}, 64'h1, lat, 0, 1'b0);
      end
    end

    // Jumps after each high read: R4 retry depth and R5 exhaustion
    for (int j = 0; j <= MAX_TRIES + 2; j++) begin
      for (int li = 0; li < 2; li++) begin
        runOne(64'h0000_0010_0000_0100, 64'h1, li * 2, j, 1'b0);
        if (j < MAX_TRIES) begin
          check(readCount == RC_W'(3 + 2 * j) && !error, "R4 retry reads",
                64'(readCount), 64'(3 + 2 * j));
        end else begin
          check(readCount == RC_W'(2 * MAX_TRIES + 1) && error, "R5 exhausted",
                64'(readCount), 64'(2 * MAX_TRIES + 1));
        end
      end
    end

    // Fast-stepping timer: frequent carries
    runOne(64'h0000_0007_FFFF_0000, 64'h4000_0000, 1, 0, 1'b0);
    runOne(64'h0000_0007_FFFF_0000, 64'h8000_0001, 0, 0, 1'b0);

    // Start pulses while busy
    runOne(64'h0000_0020_0000_0000, 64'h1, 0, 0, 1'b1);
    runOne(64'h0000_0020_0000_0000, 64'h1, 2, 3, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule